// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block decides whether a divided-down recovered clock runs at the same frequency as a local reference clock. It keeps a free-running count in the recovered-clock domain, carries that count into the reference domain in Gray code, and checks it once per measurement window of a fixed power-of-two number of reference cycles. The count difference over one window is compared with the nominal value, which equals the window length. Two separate tolerances, derived from parts-per-million settings, give hysteresis: a wide one to declare loss of lock and a narrow one to declare lock again.

The result is an active-high loss-of-lock flag. While the flag is high, the block sends the clock recovery loop a one-cycle strobe every few windows so that the loop retries acquisition. A power-down input forces both outputs low. When power-down is released, the block restarts from its reset state.

Top module: `freq_lock_mon`

## Requirements
- R1: While reset is high, and in the cycle after it, `lol` is 1 and `reacq` is 0. After reset, `lol` stays 1 until a full window has been measured within the lock tolerance.
- R2: One window is 2^WIN_LOG2 reference cycles. The window error is the number of recovered-clock edges counted in the window minus 2^WIN_LOG2. The first window after reset or power-down only records a baseline and makes no decision.
- R3: At a window end, if the magnitude of the error is greater than the loss tolerance (floor of 2^WIN_LOG2 * LOSS_PPM / 10^6), `lol` becomes 1 on the next reference clock edge.
- R4: At a window end, if the magnitude of the error is no greater than the lock tolerance (floor of 2^WIN_LOG2 * LOCK_PPM / 10^6), `lol` becomes 0.
- R5: An error magnitude between the two tolerances leaves `lol` unchanged, whichever value it held.
- R6: `lol` changes only in the cycle after a window end, or when power-down is entered or released.
- R7: `reacq` is a single-cycle pulse. It is given only while `lol` is 1, once every REACQ_WIN windows, so consecutive pulses are REACQ_WIN * 2^WIN_LOG2 reference cycles apart. No pulse occurs while locked.
- R8: From one cycle after `pwr_down` rises until it falls, `lol` and `reacq` are 0 whatever the clock frequencies. On release the block behaves as it does after reset: `lol` is 1, and it falls only after the baseline window and one in-tolerance window.
- R9: The recovered-domain count crosses clock domains in Gray code, so its registered value changes by at most one bit per recovered-clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all decision logic runs on it |
| rst | input | 1 | Synchronous active-high reset, reference domain |
| rec_clk | input | 1 | Divided-down recovered clock |
| rec_rst | input | 1 | Synchronous active-high reset, recovered domain |
| pwr_down | input | 1 | Power-down; forces outputs low and restarts measurement |
| lol | output | 1 | Loss-of-lock flag, active high |
| reacq | output | 1 | One-cycle reacquire strobe to the recovery loop |

## Verification
Assertions check on every cycle that outputs go quiet under power-down, that the flag moves only at window ends, that the reacquire strobe is one cycle wide and only occurs while unlocked, and that the Gray count steps by one bit. Only the bench scenarios can show the frequency verdicts. The bench sweeps the recovered clock period across the locked band, the hysteresis band and the loss band, on both sides of nominal and in varied order, and predicts the flag from the ideal count per window. It also measures the spacing between strobes, and it checks the restart after power-down while the clock is far off frequency.

// File: rtl/flk_pkg.sv
package flk_pkg;

    typedef enum logic {
        ST_LOCKED   = 1'b0,
        ST_UNLOCKED = 1'b1
    } lock_state_e;

    typedef struct packed {
        logic over_loss;
        logic within_lock;
    } verdict_t;

    // Count tolerance for a window of win cycles at ppm parts per million.
    function automatic int unsigned ppm_to_cnt(input longint unsigned win,
                                               input longint unsigned ppm);
        longint unsigned prod;
        prod = (win * ppm) / 64'd1000000;
        return int'(prod);
    endfunction

endpackage

// File: rtl/flk_gray_cnt.sv
module flk_gray_cnt #(
    parameter int CW = 18
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] gray_o
);
    logic [CW-1:0] bin_q;
    logic [CW-1:0] bin_nx;

    always_comb bin_nx = bin_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            bin_q  <= '0;
            gray_o <= '0;
        end else begin
            bin_q  <= bin_nx;
            gray_o <= bin_nx ^ (bin_nx >> 1);
        end
    end

    // R9
    gray_step_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(gray_o ^ $past(gray_o)) <= 1);

endmodule

// File: rtl/flk_sync.sv
module flk_sync #(
    parameter int W      = 18,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    always_comb q = stg[STAGES-1];

endmodule

// File: rtl/flk_window.sv
module flk_window #(
    parameter int WIN_LOG2 = 16
) (
    input  logic clk,
    input  logic clr,
    output logic tick
);
    logic [WIN_LOG2-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (clr) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    always_comb tick = &cnt_q;

    // R2
    tick_single_chk: assert property (@(posedge clk) disable iff (clr)
        tick |=> !tick);

endmodule

// File: rtl/flk_decide.sv
module flk_decide
    import flk_pkg::*;
#(
    parameter int          CW        = 18,
    parameter int          WIN_LOG2  = 16,
    parameter int unsigned LOSS_TOL  = 39,
    parameter int unsigned LOCK_TOL  = 19,
    parameter int          REACQ_WIN = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pd,
    input  logic          tick,
    input  logic [CW-1:0] gray_in,
    output logic          lol_o,
    output logic          reacq_o
);
    localparam int EW  = CW + 1;
    localparam int EXP = 1 << WIN_LOG2;
    localparam int RCW = $clog2(REACQ_WIN + 1);

    logic [CW-1:0]  bin_now;
    logic [CW-1:0]  prev_q;
    logic [CW-1:0]  delta;
    logic [EW-1:0]  err_u;
    logic [EW-1:0]  mag;
    verdict_t       vd;
    lock_state_e    state_q, state_d;
    logic           primed_q;
    logic [RCW-1:0] rcnt_q;

    always_comb begin
        bin_now[CW-1] = gray_in[CW-1];
        for (int i = CW - 2; i >= 0; i--) bin_now[i] = bin_now[i+1] ^ gray_in[i];
    end

    always_comb begin
        delta          = bin_now - prev_q;
        err_u          = {1'b0, delta} - EW'(EXP);
        mag            = err_u[EW-1] ? (~err_u + 1'b1) : err_u;
        vd.over_loss   = mag > EW'(LOSS_TOL);
        vd.within_lock = mag <= EW'(LOCK_TOL);
    end

    always_comb begin
        state_d = state_q;
        if (tick && primed_q) begin
            if (vd.over_loss)        state_d = ST_UNLOCKED;
            else if (vd.within_lock) state_d = ST_LOCKED;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || pd) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
            state_q  <= ST_UNLOCKED;
            rcnt_q   <= '0;
            reacq_o  <= 1'b0;
            lol_o    <= rst ? 1'b1 : 1'b0;
        end else begin
            state_q <= state_d;
            lol_o   <= (state_d == ST_UNLOCKED);
            reacq_o <= 1'b0;
            if (tick) begin
                prev_q   <= bin_now;
                primed_q <= 1'b1;
                if (state_d == ST_UNLOCKED) begin
                    if (rcnt_q == RCW'(REACQ_WIN - 1)) begin
                        rcnt_q  <= '0;
                        reacq_o <= 1'b1;
                    end else begin
                        rcnt_q <= rcnt_q + 1'b1;
                    end
                end else begin
                    rcnt_q <= '0;
                end
            end
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lol_o && !reacq_o));

    // R8
    pd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(pd)) |-> (!lol_o && !reacq_o));

    // R7
    reacq_width_chk: assert property (@(posedge clk) disable iff (rst)
        reacq_o |=> !reacq_o);

    // R7
    reacq_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
        reacq_o |-> lol_o);

    // R6
    lol_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!rst, 2) && !$past(tick) && !$past(pd) && !$past(pd, 2))
        |-> $stable(lol_o));

endmodule

// File: rtl/freq_lock_mon.sv
module freq_lock_mon
    import flk_pkg::*;
#(
    parameter int WIN_LOG2    = 16,
    parameter int LOSS_PPM    = 600,
    parameter int LOCK_PPM    = 300,
    parameter int REACQ_WIN   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst,
    input  logic rec_clk,
    input  logic rec_rst,
    input  logic pwr_down,
    output logic lol,
    output logic reacq
);
    localparam int          CW       = WIN_LOG2 + 2;
    localparam int unsigned LOSS_TOL = ppm_to_cnt(64'(1) << WIN_LOG2, 64'(LOSS_PPM));
    localparam int unsigned LOCK_TOL = ppm_to_cnt(64'(1) << WIN_LOG2, 64'(LOCK_PPM));

    logic [CW-1:0] gray_rec;
    logic [CW-1:0] gray_ref;
    logic          tick;
    logic          win_clr;

    always_comb win_clr = rst | pwr_down;

    flk_gray_cnt #(.CW(CW)) u_cnt (
        .clk    (rec_clk),
        .rst    (rec_rst),
        .gray_o (gray_rec)
    );

    flk_sync #(.W(CW), .STAGES(SYNC_STAGES)) u_sync (
        .clk (ref_clk),
        .rst (rst),
        .d   (gray_rec),
        .q   (gray_ref)
    );

    flk_window #(.WIN_LOG2(WIN_LOG2)) u_win (
        .clk  (ref_clk),
        .clr  (win_clr),
        .tick (tick)
    );

    flk_decide #(
        .CW        (CW),
        .WIN_LOG2  (WIN_LOG2),
        .LOSS_TOL  (LOSS_TOL),
        .LOCK_TOL  (LOCK_TOL),
        .REACQ_WIN (REACQ_WIN)
    ) u_dec (
        .clk     (ref_clk),
        .rst     (rst),
        .pd      (pwr_down),
        .tick    (tick),
        .gray_in (gray_ref),
        .lol_o   (lol),
        .reacq_o (reacq)
    );

endmodule

// File: tb/freq_lock_mon_tb.sv
`timescale 1ps/1ps
module freq_lock_mon_tb;
    localparam int  WIN    = 256;
    localparam int  MWIN   = 2;
    localparam real LOSS_T = 10.0;
    localparam real LOCK_T = 5.0;
    localparam int  REF_HALF = 2500;

    logic ref_clk = 0, rec_clk = 0;
    logic rst = 1, rec_rst = 1, pwr_down = 0;
    logic lol, reacq;
    int   rec_half = 2500;
    int   checks = 0, fails = 0;
    int   cyc = 0;
    logic model_lol = 1;
    bit   steady_unl = 0;
    bit   have_last = 0;
    int   last_pulse = 0;
    int   pulse_cnt = 0;
    int   toggle_cnt = 0;
    logic lol_prev = 1;

    freq_lock_mon #(.WIN_LOG2(8), .LOSS_PPM(40000), .LOCK_PPM(20000),
                    .REACQ_WIN(MWIN), .SYNC_STAGES(2)) u_dut (
        .ref_clk(ref_clk), .rst(rst), .rec_clk(rec_clk), .rec_rst(rec_rst),
        .pwr_down(pwr_down), .lol(lol), .reacq(reacq));

    always #(REF_HALF) ref_clk = ~ref_clk;
    always begin #(rec_half); rec_clk = ~rec_clk; end

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic chk_int(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(negedge ref_clk) begin
        cyc++;
        if (lol !== lol_prev) toggle_cnt++;
        lol_prev = lol;
        if (reacq) begin
            pulse_cnt++;
            chk(lol, 1'b1, "R7 strobe only while unlocked");
            if (steady_unl) begin
                if (have_last) chk_int(cyc - last_pulse, MWIN * WIN, "R7 strobe spacing");
                have_last = 1;
                last_pulse = cyc;
            end
        end
        if (!steady_unl) have_last = 0;
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    // Expected flag from the ideal edge count of one window.
    task automatic run_phase(input int half);
        real cnt, err;
        bit  hyst;
        cnt  = real'(WIN) * real'(REF_HALF) / real'(half);
        err  = cnt - real'(WIN);
        if (err < 0.0) err = -err;
        hyst = 0;
        if (err > LOSS_T)       model_lol = 1;
        else if (err <= LOCK_T) model_lol = 0;
        else                    hyst = 1;
        rec_half   = half;
        toggle_cnt = 0;
        wait_cyc(3 * WIN);
        steady_unl = model_lol;
        pulse_cnt  = 0;
        wait_cyc(4 * WIN);
        steady_unl = 0;
        if (model_lol) begin
            chk(lol, 1'b1, err > LOSS_T ? "R3 loss declared" : "R5 hysteresis keeps loss");
        end else begin
            chk(lol, 1'b0, hyst ? "R5 hysteresis keeps lock" : "R4 lock declared");
            chk_int(pulse_cnt, 0, "R7 no strobe while locked");
        end
        if (hyst) chk_int(toggle_cnt, 0, "R5 flag steady in hysteresis band");
    endtask

    initial begin
        int halves [14] = '{2500, 2471, 2581, 2656, 2581, 2540, 2370,
                            2420, 2500, 2420, 2300, 2420, 2520, 2640};
        wait_cyc(4);
        chk(lol, 1'b1, "R1 flag high in reset");
        chk(reacq, 1'b0, "R1 no strobe in reset");
        rst = 0; rec_rst = 0;
        wait_cyc(2);
        chk(lol, 1'b1, "R1 flag high after reset");
        wait_cyc(WIN + 20);
        chk(lol, 1'b1, "R2 baseline window makes no decision");
        foreach (halves[i]) run_phase(halves[i]);

        // Power-down while far off frequency.
        rec_half = 2656;
        wait_cyc(4 * WIN);
        chk(lol, 1'b1, "R3 off frequency before power-down");
        pwr_down = 1;
        wait_cyc(2);
        chk(lol, 1'b0, "R8 flag forced low");
        pulse_cnt = 0;
        wait_cyc(5 * WIN);
        chk(lol, 1'b0, "R8 flag stays low");
        chk_int(pulse_cnt, 0, "R8 no strobe in power-down");
        rec_half = 2500;
        wait_cyc(2 * WIN);
        pwr_down = 0;
        wait_cyc(2);
        chk(lol, 1'b1, "R8 restart with flag high");
        wait_cyc(WIN + 40);
        chk(lol, 1'b1, "R8 baseline window after release");
        wait_cyc(WIN + 40);
        chk(lol, 1'b0, "R8 lock after first in-range window");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge ref_clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule